// File: doc/BRIEF.md
# CAN Controller Control and Status Registers

This block is the register front end of a CAN controller whose frames move through a bus-master DMA path. It holds a control word with an enable bit and a self-clearing whole-core reset bit. It also builds a status word from live values supplied by the protocol core (error counters, transmit activity, bus-off, error-passive) and from two sticky event flags, overrun and bus-master error. A read of the status word clears both flags.

The block also owns the CAN transmit pin. While the controller is disabled it drives only the recessive level (sleep). After enable it counts recessive bits received on the bus, one per bit-time strobe. Only after a run of `IDLE_BITS` consecutive recessive bits does it report the bus as ready and pass the core's transmit level to the pin. Bit timing, error-counter rules, framing and the DMA engine are outside this block. They appear only as strobes and counter values.

Top module: `can_ctlstat`

## Requirements
- R1: After `rst_n` is released, the control and status words both read 0 whatever the input values, `can_tx` is 1, and `traffic_ok`, `core_en` and `core_rst` are 0.
- R2: A write to word index 0 (control) stores bit 0 as the enable. `core_en` follows it, and bit 0 reads back the stored value.
- R3: Writing 1 to control bit 1 raises `core_rst` for exactly the next cycle. In the same edge it clears the enable, both sticky flags and the bus-ready state. Control bit 1 always reads back 0.
- R4: Status (word index 1) packs the transmit error counter at bits 23:16, the receive error counter at bits 15:8, transmit activity at bit 4, bus-off at bit 1 and error-passive at bit 0. These live fields read 0 while disabled. Reserved bits and unmapped indices read 0.
- R5: A `rx_drop` strobe while enabled sets the sticky overrun flag at status bit 2.
- R6: A `dma_err` strobe sets the sticky bus-master error flag at status bit 3 only while `cfg_abort` is 1.
- R7: A status read returns the flags and then clears them. A set event in the same cycle as the read wins, so the flag is 1 afterwards.
- R8: While the enable is 0, `can_tx` is 1 (recessive) regardless of `core_tx`.
- R9: After enable, `traffic_ok` rises in the cycle after the `IDLE_BITS`-th (default 10) consecutive recessive `bit_tick`. Until then `can_tx` stays 1. After that `can_tx` equals `core_tx`.
- R10: A `bit_tick` with `can_rx` = 0 before bus-ready restarts the recessive count from zero.
- R11: The recessive count advances only on cycles with `bit_tick` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Word index (0 control, 1 status) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; status read clears flags |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| cfg_abort | input | 1 | Abort-on-bus-error option |
| dma_err | input | 1 | Bus-master error strobe |
| rx_drop | input | 1 | Matching frame could not be stored |
| tx_err_cnt | input | 8 | Transmit error counter from core |
| rx_err_cnt | input | 8 | Receive error counter from core |
| tx_active | input | 1 | Transmission in progress |
| bus_off | input | 1 | Bus-off condition |
| err_passive | input | 1 | Error-passive condition |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| can_rx | input | 1 | Sampled bus level (1 recessive) |
| core_tx | input | 1 | Transmit level from protocol core |
| can_tx | output | 1 | Transmit pin level |
| core_en | output | 1 | Enable to protocol core (0 holds it in reset) |
| core_rst | output | 1 | One-cycle whole-core reset pulse |
| traffic_ok | output | 1 | Bus-ready: recessive run seen |

## Verification
The assertions check on every cycle that the pin stays recessive while disabled or not bus-ready, that bus-ready only rises after a recessive strobe at the last count, that a dominant strobe restarts the count, and that the count holds without a strobe. They also check that a set event always leaves its flag at 1, that a read without a set clears it, that the bus-master flag never rises without the abort option, and that the reset pulse leaves the enable at 0. Only the bench scenarios can show the status bit layout under several value patterns, the exact tick on which bus-ready appears, and the read-back values after a core reset.

// File: rtl/canreg_pkg.sv
package canreg_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ERR_W  = 8;
  localparam int unsigned NFLAG  = 2;
  localparam int unsigned FL_OVR = 0;
  localparam int unsigned FL_BME = 1;

  typedef struct packed {
    logic [ERR_W-1:0] tec;
    logic [ERR_W-1:0] rec;
    logic             active;
    logic             bm_err;
    logic             overrun;
    logic             bus_off;
    logic             passive;
  } stat_t;

  // status word: counters in the upper half, event/condition bits low
  function automatic logic [REG_W-1:0] pack_status(stat_t s);
    logic [REG_W-1:0] w;
    w        = '0;
    w[23:16] = s.tec;
    w[15:8]  = s.rec;
    w[4]     = s.active;
    w[3]     = s.bm_err;
    w[2]     = s.overrun;
    w[1]     = s.bus_off;
    w[0]     = s.passive;
    return w;
  endfunction

  // control word: only the enable is held; the reset bit never reads back
  function automatic logic [REG_W-1:0] pack_ctrl(logic en);
    logic [REG_W-1:0] w;
    w    = '0;
    w[0] = en;
    return w;
  endfunction

  // next value of a recessive-run counter on a bit strobe
  function automatic int unsigned idle_next(int unsigned cnt, logic rx);
    return rx ? cnt + 1 : 0;
  endfunction
endpackage

// File: rtl/can_ctrl_reg.sv
module can_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic wdata_en,
  input  logic wdata_rst,
  output logic soft_req,
  output logic en_o,
  output logic core_rst_o
);
  logic en_q, rst_q;

  assign soft_req = wr_ctrl & wdata_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= soft_req;
      if (wr_ctrl) en_q <= wdata_en & ~wdata_rst;
    end
  end

  assign en_o       = en_q;
  assign core_rst_o = rst_q;

  AST_RST_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> !en_o); // R3
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o && !soft_req |=> !core_rst_o); // R3
endmodule

// File: rtl/can_sticky_flags.sv
module can_sticky_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         rd_clr,
  input  logic         flush,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= 1'b0;
      else if (flush)     q <= 1'b0;
      else if (set_i[i])  q <= 1'b1;
      else if (rd_clr)    q <= 1'b0;
    end
    assign flag_o[i] = q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] && !flush |=> flag_o[i]); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr && !set_i[i] |=> !flag_o[i]); // R7
  end
endmodule

// File: rtl/can_idle_gate.sv
module can_idle_gate #(
  parameter int unsigned IDLE_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic flush,
  input  logic bit_tick,
  input  logic rx,
  input  logic core_tx,
  output logic ok_o,
  output logic tx_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_BITS + 1);
  localparam int unsigned LAST  = IDLE_BITS - 1;

  logic [CNT_W-1:0] cnt_q;
  logic             ok_q;
  logic             run_done;

  assign run_done = bit_tick & rx & (int'(cnt_q) == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (!en || flush) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (!ok_q && bit_tick) begin
      cnt_q <= CNT_W'(canreg_pkg::idle_next(int'(cnt_q), rx));
      if (run_done) ok_q <= 1'b1;
    end
  end

  assign ok_o = ok_q;
  assign tx_o = (en && ok_q) ? core_tx : 1'b1;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= IDLE_BITS); // R9
  AST_READY_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_o) |-> $past(bit_tick && rx && int'(cnt_q) == LAST)); // R9
  AST_DOMINANT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    en && !flush && !ok_q && bit_tick && !rx |=> cnt_q == '0); // R10
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    en && !flush && !bit_tick |=> $stable(cnt_q)); // R11
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_o |-> tx_o); // R9
endmodule

// File: rtl/can_ctlstat.sv
module can_ctlstat #(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned CTRL_IDX  = 0,
  parameter int unsigned STAT_IDX  = 1,
  parameter int unsigned IDLE_BITS = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic [canreg_pkg::REG_W-1:0] reg_wdata,
  output logic [canreg_pkg::REG_W-1:0] reg_rdata,
  input  logic                         cfg_abort,
  input  logic                         dma_err,
  input  logic                         rx_drop,
  input  logic [canreg_pkg::ERR_W-1:0] tx_err_cnt,
  input  logic [canreg_pkg::ERR_W-1:0] rx_err_cnt,
  input  logic                         tx_active,
  input  logic                         bus_off,
  input  logic                         err_passive,
  input  logic                         bit_tick,
  input  logic                         can_rx,
  input  logic                         core_tx,
  output logic                         can_tx,
  output logic                         core_en,
  output logic                         core_rst,
  output logic                         traffic_ok
);
  import canreg_pkg::*;

  logic             sel_ctrl, sel_stat;
  logic             wr_ctrl, rd_stat, soft_req;
  logic [NFLAG-1:0] flag_set, flags;
  logic             unused_wdata;
  stat_t            st;

  assign sel_ctrl     = (reg_addr == ADDR_W'(CTRL_IDX));
  assign sel_stat     = (reg_addr == ADDR_W'(STAT_IDX));
  assign wr_ctrl      = reg_wr & sel_ctrl;
  assign rd_stat      = reg_rd & sel_stat;
  assign unused_wdata = ^reg_wdata[REG_W-1:2];

  can_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .wdata_en   (reg_wdata[0]),
    .wdata_rst  (reg_wdata[1]),
    .soft_req   (soft_req),
    .en_o       (core_en),
    .core_rst_o (core_rst)
  );

  assign flag_set[FL_OVR] = rx_drop & core_en;
  assign flag_set[FL_BME] = dma_err & cfg_abort;

  can_sticky_flags #(.N(NFLAG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .rd_clr (rd_stat),
    .flush  (soft_req),
    .flag_o (flags)
  );

  can_idle_gate #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (core_en),
    .flush    (soft_req),
    .bit_tick (bit_tick),
    .rx       (can_rx),
    .core_tx  (core_tx),
    .ok_o     (traffic_ok),
    .tx_o     (can_tx)
  );

  always_comb begin
    st         = '0;
    st.bm_err  = flags[FL_BME];
    st.overrun = flags[FL_OVR];
    if (core_en) begin
      st.tec     = tx_err_cnt;
      st.rec     = rx_err_cnt;
      st.active  = tx_active;
      st.bus_off = bus_off;
      st.passive = err_passive;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (sel_ctrl)      reg_rdata = pack_ctrl(core_en);
      else if (sel_stat) reg_rdata = pack_status(st);
    end
  end

  AST_SLEEP_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |-> can_tx); // R8
  AST_BME_NEEDS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FL_BME]) |-> $past(cfg_abort && dma_err)); // R6
  AST_OVR_NEEDS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FL_OVR]) |-> $past(rx_drop && core_en)); // R5
  AST_CTRL_RST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && sel_ctrl |-> !reg_rdata[1]); // R3
endmodule

// File: tb/tb_can_ctlstat.sv
module tb_can_ctlstat;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cfg_abort = 1'b0, dma_err = 1'b0, rx_drop = 1'b0;
  logic [7:0]  tx_err_cnt = '0, rx_err_cnt = '0;
  logic        tx_active = 1'b0, bus_off = 1'b0, err_passive = 1'b0;
  logic        bit_tick = 1'b0, can_rx = 1'b1, core_tx = 1'b1;
  logic        can_tx, core_en, core_rst, traffic_ok;

  int n_chk = 0, n_bad = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_ctlstat dut (.*);

  // {tec, rec, active, bus_off, passive, expected status}
  localparam logic [50:0] VEC [4] = '{
    {8'h5A, 8'hC3, 1'b1, 1'b0, 1'b1, 32'h005AC311},
    {8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 32'h00FF0002},
    {8'h00, 8'h7F, 1'b1, 1'b1, 1'b1, 32'h00007F13},
    {8'h80, 8'h01, 1'b0, 1'b0, 1'b0, 32'h00800100}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rdw(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic tick(input logic lvl);
    @(negedge clk); can_rx = lvl; bit_tick = 1'b1;
    @(posedge clk); #1 bit_tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tx_err_cnt = 8'hAA; rx_err_cnt = 8'h55; tx_active = 1'b1; bus_off = 1'b1; err_passive = 1'b1;
    core_tx = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rdw(2'd0, rd); check("R1 ctrl", rd, 32'h0);
    rdw(2'd1, rd); check("R1 status", rd, 32'h0);
    check("R1 pins", {28'h0, can_tx, traffic_ok, core_en, core_rst}, 32'h8);
    // R8 sleep
    check("R8 tx recessive", {31'h0, can_tx}, 32'h1);
    // R2 enable
    wr(2'd0, 32'h1);
    rdw(2'd0, rd); check("R2 ctrl readback", rd, 32'h1);
    check("R2 core_en", {31'h0, core_en}, 32'h1);
    // R4 layout table
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      {tx_err_cnt, rx_err_cnt, tx_active, bus_off, err_passive} = VEC[i][50:32];
      rdw(2'd1, rd); check("R4 status layout", rd, VEC[i][31:0]);
    end
    rdw(2'd2, rd); check("R4 unmapped", rd, 32'h0);
    // R9 not ready yet, pin held recessive
    check("R9 hold-off", {31'h0, can_tx}, 32'h1);
    // R9 ten recessive ticks
    for (int i = 0; i < 9; i++) tick(1'b1);
    check("R9 after 9", {31'h0, traffic_ok}, 32'h0);
    tick(1'b1);
    check("R9 after 10", {31'h0, traffic_ok}, 32'h1);
    check("R9 tx follows core", {31'h0, can_tx}, 32'h0);
    // R5 overrun
    @(negedge clk); rx_drop = 1'b1; @(posedge clk); #1 rx_drop = 1'b0;
    rdw(2'd1, rd); check("R5 overrun set", {31'h0, rd[2]}, 32'h1);
    rdw(2'd1, rd); check("R7 read cleared", {31'h0, rd[2]}, 32'h0);
    // R6 abort gating
    @(negedge clk); cfg_abort = 1'b0; dma_err = 1'b1; @(posedge clk); #1 dma_err = 1'b0;
    rdw(2'd1, rd); check("R6 no abort", {31'h0, rd[3]}, 32'h0);
    @(negedge clk); cfg_abort = 1'b1; dma_err = 1'b1; @(posedge clk); #1 dma_err = 1'b0;
    rdw(2'd1, rd); check("R6 abort set", {31'h0, rd[3]}, 32'h1);
    // R7 set wins over read
    @(negedge clk); dma_err = 1'b1; rx_drop = 1'b1; reg_addr = 2'd1; reg_rd = 1'b1;
    @(posedge clk); #1 reg_rd = 1'b0; dma_err = 1'b0; rx_drop = 1'b0;
    rdw(2'd1, rd); check("R7 set wins", {30'h0, rd[3:2]}, 32'h3);
    rdw(2'd1, rd); check("R7 cleared", {30'h0, rd[3:2]}, 32'h0);
    // R3 core reset
    @(negedge clk); rx_drop = 1'b1; @(posedge clk); #1 rx_drop = 1'b0;
    wr(2'd0, 32'h3);
    check("R3 pulse", {31'h0, core_rst}, 32'h1);
    @(posedge clk); #1 check("R3 pulse ends", {31'h0, core_rst}, 32'h0);
    rdw(2'd0, rd); check("R3 ctrl reads 0", rd, 32'h0);
    rdw(2'd1, rd); check("R3 flags/live 0", rd, 32'h0);
    check("R3 ready cleared", {30'h0, traffic_ok, can_tx}, 32'h1);
    check("R8 sleep after reset", {31'h0, can_tx}, 32'h1);
    // R10 dominant restarts
    wr(2'd0, 32'h1);
    for (int i = 0; i < 5; i++) tick(1'b1);
    tick(1'b0);
    for (int i = 0; i < 9; i++) tick(1'b1);
    check("R10 restarted", {31'h0, traffic_ok}, 32'h0);
    tick(1'b1);
    check("R10 ready", {31'h0, traffic_ok}, 32'h1);
    // R11 no tick, no advance
    wr(2'd0, 32'h0);
    wr(2'd0, 32'h1);
    for (int i = 0; i < 9; i++) tick(1'b1);
    @(negedge clk); can_rx = 1'b1;
    repeat (20) @(posedge clk);
    #1 check("R11 no advance", {31'h0, traffic_ok}, 32'h0);
    tick(1'b1);
    check("R11 tenth tick", {31'h0, traffic_ok}, 32'h1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule